// File: doc/BRIEF.md
# Dual-Mode Coprocessor Bus Slave

This block is the host-facing front end of a coprocessor. It presents a synchronous, memory-mapped slave to a host processor bus. Behind it sit a small register file, a 128-word input FIFO and a 128-word output FIFO. The coprocessor's execution units are modelled here as plain 32-bit registers, each with an interrupt input.

A strap input picks one of two bus protocols, and the same sequencer serves both:

- **Acknowledge protocol.** The host qualifies chip select with a transfer-start strobe. The slave answers with an active-low acknowledge once its wait states have elapsed.
- **Wait/data-valid protocol.** Chip select alone opens a transfer. The slave holds an active-high wait line while it is not ready, and the host marks each data beat with an active-low data-valid strobe. In this protocol the host may burst into the input FIFO or out of the output FIFO.

The block also decodes the address into targets and optionally swaps byte lanes for little-endian hosts. It drives two DMA request lines and merges the unit interrupts into one active-low line. The coprocessor side drains the input FIFO and fills the output FIFO through simple pop/push ports.

Top module: `cpbus_slave`

## Requirements
- R1: While `rst` is high: `ack_n`=1, `wait_o`=0, `irq_n`=1, `dreq`=0, `rdata`=0 and `in_empty`=1. The DMA select register resets to 0.
- R2: With `mode_sel`=0, a transfer starts only on a rising edge where `ts_n`=0 and `cs_n`=0. `rd_wr` is sampled there (1 read, 0 write). Chip select without the start strobe starts nothing, and `ack_n` never goes low while `mode_sel`=1.
- R3: With `mode_sel`=0, `ack_n` stays high for the wait cycles and then goes low for exactly one cycle.
  - Unit registers take 2 wait cycles. All other targets take 0, so `ack_n` is low in the cycle right after the start edge.
  - Read data is valid while `ack_n` is low, and write data is captured on the edge that ends that cycle.
- R4: With `mode_sel`=0, `dval_n` has no effect and `burst_n` is ignored: a transfer is always one beat.
- R5: With `mode_sel`=1, a transfer starts on an edge where `cs_n`=0. `wait_o` is high for the wait cycles (2 for unit registers) and `wait_o` is never high while `mode_sel`=0. Each beat is an edge with `wait_o`=0 and `dval_n`=0: write data is captured there, and read data is valid in that cycle.
- R6: With `mode_sel`=1 and `burst_n`=0, a write to the input FIFO or a read from the output FIFO is a 4-beat burst. The first beat follows 2 wait cycles and the later beats take no wait cycles.
- R7: A burst request to any other target is served as a single beat.
- R8: Address map, by word address. Host bit 0 (the MSB) is `addr[11]` and `wdata/rdata[31]`.
  - 0x000: constant ID register, reading 0x5EC00001.
  - 0x001: DMA select register, bits [1:0].
  - 0x100–0x1FF: input FIFO (write).
  - 0x200–0x2FF: output FIFO (read).
  - 0x400/0x500/0x600/0x700: unit registers 0 to 3, each independently read/write.
  - Any other address reads 0, and writes to it are dropped.
- R9: When `big_end`=0, bytes are swapped in both directions: [7:0]↔[31:24] and [15:8]↔[23:16]. When `big_end`=1, data passes unchanged.
- R10: A write to the full input FIFO, or a read from the empty output FIFO, holds off the beat (`ack_n` high, or `wait_o` high) until space or data is available. The beat then completes with the right data.
- R11: `dreq[i]` is registered and follows DMA select bit i.
  - Bit i = 0: `dreq[i]` signals that the input FIFO is not full.
  - Bit i = 1: `dreq[i]` signals that the output FIFO is not empty.
- R12: `irq_n` is low one cycle after any `eu_irq` bit is high, and high one cycle after all bits are low.
- R13: The FIFOs keep word order. `in_data` shows the input FIFO head and `in_pop` removes it. `out_push` appends `out_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Protocol strap: 0 acknowledge, 1 wait/data-valid |
| ts_n | input | 1 | Transfer start, active low (mode 0) |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 read, 0 write |
| burst_n | input | 1 | Burst request, active low (mode 1) |
| dval_n | input | 1 | Data-valid strobe, active low (mode 1) |
| big_end | input | 1 | 1 big-endian, 0 byte-swapped |
| addr | input | 12 | Word address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, zero outside a read beat |
| ack_n | output | 1 | Transfer acknowledge, active low (mode 0) |
| wait_o | output | 1 | Wait request, active high (mode 1) |
| irq_n | output | 1 | Merged interrupt, active low |
| dreq | output | 2 | DMA requests, active high |
| eu_irq | input | 4 | Execution-unit interrupt inputs |
| in_pop | input | 1 | Coprocessor pops the input FIFO |
| in_data | output | 32 | Input FIFO head |
| in_empty | output | 1 | Input FIFO empty |
| out_push | input | 1 | Coprocessor pushes the output FIFO |
| out_wdata | input | 32 | Output FIFO push data |
| out_full | output | 1 | Output FIFO full |

## Verification
The bench attacks the wait-count boundaries: 0 versus 2 cycles per target, and 2 on the first burst beat then 0 after it. A sequencer that counted one cycle too many or too few would show up as a shifted acknowledge or an extra wait cycle. It drives a burst toward a unit register followed by a stray data-valid strobe, which catches a design that keeps bursting or writes outside a transfer. It fills the input FIFO to 128 words and reads the output FIFO while empty. A design without back-pressure would acknowledge into a full buffer and lose or reorder words, or return stale data. Mixed endian writes and reads, plus data-valid and burst inputs toggled in the acknowledge protocol, expose missing swaps on one path and leakage between the two protocols.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  // Access target produced by the address decoder
  typedef enum logic [2:0] {
    T_NONE  = 3'd0,
    T_ID    = 3'd1,
    T_DMA   = 3'd2,
    T_IFIFO = 3'd3,
    T_OFIFO = 3'd4,
    T_EU    = 3'd5
  } tgt_e;

  // Transfer sequencer states
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_BUSY = 2'd1,
    S_BEAT = 2'd2
  } seq_e;

endpackage

// File: rtl/cpbus_fifo.sv
module cpbus_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW:0]   wp, rp;

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  assign head  = mem[rp[PW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
endmodule

// File: rtl/cpbus_decode.sv
module cpbus_decode
  import cpbus_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NUM_EU = 4,
  parameter int IW     = 2
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt,
  output logic [IW-1:0] eu_idx
);
  always_comb begin
    tgt    = T_NONE;
    eu_idx = addr[AW-4 +: IW];
    if (addr[AW-1 -: 2] == 2'b01) begin
      if ({1'b0, eu_idx} < (IW+1)'(NUM_EU)) tgt = T_EU;
    end else begin
      case (addr[AW-1 -: 4])
        4'h0: begin
          if (addr[AW-5:0] == '0)               tgt = T_ID;
          else if (addr[AW-5:0] == (AW-4)'(1))  tgt = T_DMA;
        end
        4'h1:    tgt = T_IFIFO;
        4'h2:    tgt = T_OFIFO;
        default: tgt = T_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cpbus_seq.sv
module cpbus_seq
  import cpbus_pkg::*;
#(
  parameter int WAIT_EU     = 2,
  parameter int WAIT_BURST  = 2,
  parameter int BURST_BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic ts_n,
  input  logic cs_n,
  input  logic rd_wr,
  input  logic burst_n,
  input  logic dval_n,
  input  tgt_e tgt_in,
  input  logic in_full,
  input  logic out_empty,
  output tgt_e tgt_q,
  output logic rd_q,
  output logic start,
  output logic data_ok,
  output logic beat_fire,
  output logic ack_n,
  output logic wait_o
);
  localparam int WMAX = (WAIT_EU > WAIT_BURST) ? WAIT_EU : WAIT_BURST;
  localparam int CW   = (WMAX < 1) ? 1 : $clog2(WMAX + 1);
  localparam int BW   = (BURST_BEATS < 2) ? 1 : $clog2(BURST_BEATS);

  seq_e          st;
  logic [CW-1:0] cnt, wait_init;
  logic [BW-1:0] left;
  logic          burst_ok, fifo_ok;

  always_comb begin
    start     = (st == S_IDLE) && !cs_n && (mode_sel || !ts_n);
    burst_ok  = mode_sel && !burst_n &&
                ((tgt_in == T_IFIFO && !rd_wr) || (tgt_in == T_OFIFO && rd_wr));
    wait_init = (tgt_in == T_EU) ? CW'(WAIT_EU) :
                burst_ok         ? CW'(WAIT_BURST) : '0;
    fifo_ok   = (tgt_q == T_IFIFO && !rd_q) ? !in_full :
                (tgt_q == T_OFIFO &&  rd_q) ? !out_empty : 1'b1;
    data_ok   = (st == S_BEAT) && fifo_ok;
    beat_fire = data_ok && (!mode_sel || !dval_n);
    ack_n     = !(data_ok && !mode_sel);
    wait_o    = mode_sel && ((st == S_BUSY) || (st == S_BEAT && !fifo_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      left  <= '0;
      tgt_q <= T_NONE;
      rd_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tgt_q <= tgt_in;
          rd_q  <= rd_wr;
          cnt   <= wait_init;
          left  <= burst_ok ? BW'(BURST_BEATS - 1) : '0;
          st    <= (wait_init == '0) ? S_BEAT : S_BUSY;
        end
        S_BUSY: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= S_BEAT;
        end
        S_BEAT: if (beat_fire) begin
          if (left == '0) st <= S_IDLE;
          else            left <= left - BW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpbus_slave.sv
module cpbus_slave
  import cpbus_pkg::*;
#(
  parameter int          AW          = 12,
  parameter int          DW          = 32,
  parameter int          FIFO_DEPTH  = 128,
  parameter int          NUM_EU      = 4,
  parameter int          NUM_DREQ    = 2,
  parameter int          WAIT_EU     = 2,
  parameter int          WAIT_BURST  = 2,
  parameter int          BURST_BEATS = 4,
  parameter logic [31:0] ID_VALUE    = 32'h5EC0_0001
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_sel,
  input  logic                ts_n,
  input  logic                cs_n,
  input  logic                rd_wr,
  input  logic                burst_n,
  input  logic                dval_n,
  input  logic                big_end,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                ack_n,
  output logic                wait_o,
  output logic                irq_n,
  output logic [NUM_DREQ-1:0] dreq,
  input  logic [NUM_EU-1:0]   eu_irq,
  input  logic                in_pop,
  output logic [DW-1:0]       in_data,
  output logic                in_empty,
  input  logic                out_push,
  input  logic [DW-1:0]       out_wdata,
  output logic                out_full
);
  localparam int IW    = (NUM_EU > 1) ? $clog2(NUM_EU) : 1;
  localparam int LANES = DW / 8;

  tgt_e                tgt_live, tgt_q;
  logic [IW-1:0]       idx_live, eu_idx_q;
  logic                rd_q, start, data_ok, beat_fire;
  logic                in_full_w, out_empty_w;
  logic [DW-1:0]       wswap, win, rmux, rswap, ohead;
  logic [NUM_DREQ-1:0] dma_sel_q, dreq_q;
  logic                irq_q;
  logic [DW-1:0]       eu_q [NUM_EU];

  cpbus_decode #(.AW(AW), .NUM_EU(NUM_EU), .IW(IW)) u_dec (
    .addr(addr), .tgt(tgt_live), .eu_idx(idx_live)
  );

  cpbus_seq #(
    .WAIT_EU(WAIT_EU), .WAIT_BURST(WAIT_BURST), .BURST_BEATS(BURST_BEATS)
  ) u_seq (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ts_n(ts_n), .cs_n(cs_n),
    .rd_wr(rd_wr), .burst_n(burst_n), .dval_n(dval_n), .tgt_in(tgt_live),
    .in_full(in_full_w), .out_empty(out_empty_w), .tgt_q(tgt_q), .rd_q(rd_q),
    .start(start), .data_ok(data_ok), .beat_fire(beat_fire),
    .ack_n(ack_n), .wait_o(wait_o)
  );

  // byte-lane reversal, both directions
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wswap[8*l +: 8] = wdata[DW-8-8*l +: 8];
    assign rswap[8*l +: 8] = rmux[DW-8-8*l +: 8];
  end
  assign win = big_end ? wdata : wswap;

  always_ff @(posedge clk) begin
    if (rst)        eu_idx_q <= '0;
    else if (start) eu_idx_q <= idx_live;
  end

  cpbus_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_ififo (
    .clk(clk), .rst(rst),
    .push(beat_fire && !rd_q && tgt_q == T_IFIFO), .push_data(win),
    .pop(in_pop), .head(in_data), .full(in_full_w), .empty(in_empty)
  );

  cpbus_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_ofifo (
    .clk(clk), .rst(rst),
    .push(out_push), .push_data(out_wdata),
    .pop(beat_fire && rd_q && tgt_q == T_OFIFO), .head(ohead),
    .full(out_full), .empty(out_empty_w)
  );

  for (genvar g = 0; g < NUM_EU; g++) begin : g_eu
    always_ff @(posedge clk) begin
      if (rst) eu_q[g] <= '0;
      else if (beat_fire && !rd_q && tgt_q == T_EU && eu_idx_q == IW'(g))
        eu_q[g] <= win;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dma_sel_q <= '0;
    else if (beat_fire && !rd_q && tgt_q == T_DMA) dma_sel_q <= win[NUM_DREQ-1:0];
  end

  always_comb begin
    case (tgt_q)
      T_ID:    rmux = DW'(ID_VALUE);
      T_DMA:   rmux = DW'(dma_sel_q);
      T_OFIFO: rmux = ohead;
      T_EU:    rmux = eu_q[eu_idx_q];
      default: rmux = '0;
    endcase
  end

  assign rdata = (data_ok && rd_q) ? (big_end ? rmux : rswap) : '0;

  for (genvar d = 0; d < NUM_DREQ; d++) begin : g_dreq
    always_ff @(posedge clk) begin
      if (rst) dreq_q[d] <= 1'b0;
      else     dreq_q[d] <= dma_sel_q[d] ? !out_empty_w : !in_full_w;
    end
  end
  assign dreq = dreq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b1;
    else     irq_q <= ~|eu_irq;
  end
  assign irq_n = irq_q;
endmodule

// File: rtl/cpbus_slave_chk.sv
module cpbus_slave_chk #(
  parameter int NUM_EU   = 4,
  parameter int NUM_DREQ = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_sel,
  input logic                ack_n,
  input logic                wait_o,
  input logic                irq_n,
  input logic [NUM_EU-1:0]   eu_irq,
  input logic [NUM_DREQ-1:0] dreq,
  input logic [NUM_DREQ-1:0] dma_sel,
  input logic                in_full
);
  a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> ack_n);

  a_r2_ack_mode0_only: assert property (@(posedge clk) disable iff (rst)
    mode_sel |-> ack_n);

  a_r5_wait_mode1_only: assert property (@(posedge clk) disable iff (rst)
    !mode_sel |-> !wait_o);

  a_r12_irq_set: assert property (@(posedge clk) disable iff (rst)
    (|eu_irq) |=> !irq_n);

  a_r12_irq_clear: assert property (@(posedge clk) disable iff (rst)
    !(|eu_irq) |=> irq_n);

  a_r11_dreq_input: assert property (@(posedge clk) disable iff (rst)
    (!dma_sel[0] && !in_full) |=> dreq[0]);
endmodule

bind cpbus_slave cpbus_slave_chk #(.NUM_EU(NUM_EU), .NUM_DREQ(NUM_DREQ)) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .ack_n(ack_n), .wait_o(wait_o),
  .irq_n(irq_n), .eu_irq(eu_irq), .dreq(dreq), .dma_sel(dma_sel_q),
  .in_full(in_full_w)
);

// File: tb/tb_cpbus_slave.sv
module tb_cpbus_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b0, ts_n = 1'b1, cs_n = 1'b1, rd_wr = 1'b0;
  logic        burst_n = 1'b1, dval_n = 1'b1, big_end = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, in_data, out_wdata = '0;
  logic        ack_n, wait_o, irq_n, in_empty, out_full;
  logic        in_pop = 1'b0, out_push = 1'b0;
  logic [1:0]  dreq;
  logic [3:0]  eu_irq = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] beat_wd [4];
  logic [31:0] beat_rd [4];
  int first_waits, later_waits;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpbus_slave dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ts_n(ts_n), .cs_n(cs_n),
    .rd_wr(rd_wr), .burst_n(burst_n), .dval_n(dval_n), .big_end(big_end),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .wait_o(wait_o),
    .irq_n(irq_n), .dreq(dreq), .eu_irq(eu_irq), .in_pop(in_pop),
    .in_data(in_data), .in_empty(in_empty), .out_push(out_push),
    .out_wdata(out_wdata), .out_full(out_full)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // acknowledge-protocol single transfer
  task automatic m0_xfer(input logic rd, input logic [11:0] a, input logic [31:0] wd,
                         input logic brst, output logic [31:0] rv, output int waits);
    @(negedge clk);
    ts_n = 0; cs_n = 0; rd_wr = rd; addr = a; wdata = wd; burst_n = !brst;
    @(negedge clk);
    ts_n = 1; cs_n = 1; burst_n = 1;
    waits = 0;
    while (ack_n && waits < 400) begin waits++; @(negedge clk); end
    if (waits >= 400) waits = -1;
    rv = rdata;
    @(negedge clk);
  endtask

  // wait/data-valid protocol transfer of n beats
  task automatic m1_xfer(input logic rd, input logic [11:0] a, input logic brst,
                         input int n);
    int k = 0;
    int guard = 0;
    @(negedge clk);
    cs_n = 0; rd_wr = rd; addr = a; burst_n = !brst;
    @(negedge clk);
    cs_n = 1; burst_n = 1;
    first_waits = 0; later_waits = 0;
    while (k < n && guard < 400) begin
      if (!wait_o) begin
        wdata = beat_wd[k]; beat_rd[k] = rdata; dval_n = 0; k++;
      end else begin
        dval_n = 1;
        if (k == 0) first_waits++; else later_waits++;
      end
      @(negedge clk);
      guard++;
    end
    dval_n = 1;
    if (guard >= 400) first_waits = -1;
  endtask

  task automatic pop_in(output logic [31:0] v);
    @(negedge clk);
    v = in_data; in_pop = 1;
    @(negedge clk);
    in_pop = 0;
  endtask

  task automatic push_out(input logic [31:0] v);
    @(negedge clk);
    out_push = 1; out_wdata = v;
    @(negedge clk);
    out_push = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "ack_n in reset", 32'(ack_n), 32'd1);
    chk("R1", "wait_o in reset", 32'(wait_o), 32'd0);
    chk("R1", "irq_n in reset", 32'(irq_n), 32'd1);
    chk("R1", "dreq in reset", 32'(dreq), 32'd0);
    chk("R1", "rdata in reset", rdata, 32'd0);
    chk("R1", "in_empty in reset", 32'(in_empty), 32'd1);
    rst = 0;
    @(negedge clk);
    chk("R11", "dreq after reset, select 0", 32'(dreq), 32'b11);
  endtask

  task automatic t_m0_basic();
    logic [31:0] v; int w;
    mode_sel = 0;
    m0_xfer(1, 12'h000, 0, 0, v, w);
    chk("R8", "ID value", v, 32'h5EC0_0001);
    chk("R3", "ID wait cycles", 32'(w), 32'd0);
    m0_xfer(0, 12'h500, 32'hA5A5_0001, 0, v, w);
    chk("R3", "unit write wait cycles", 32'(w), 32'd2);
    m0_xfer(0, 12'h700, 32'h0000_0777, 0, v, w);
    m0_xfer(1, 12'h500, 0, 0, v, w);
    chk("R8", "unit 1 readback", v, 32'hA5A5_0001);
    chk("R3", "unit read wait cycles", 32'(w), 32'd2);
    m0_xfer(1, 12'hC00, 0, 0, v, w);
    chk("R8", "unmapped read", v, 32'd0);
  endtask

  task automatic t_m0_no_ts();
    int lows = 0;
    @(negedge clk);
    cs_n = 0; rd_wr = 1; addr = 12'h000;
    repeat (8) begin @(negedge clk); if (!ack_n) lows++; end
    cs_n = 1;
    chk("R2", "ack without transfer-start", 32'(lows), 32'd0);
  endtask

  task automatic t_m0_ignored();
    logic [31:0] v; int w;
    dval_n = 1;
    m0_xfer(0, 12'h600, 32'h0000_6606, 0, v, w);
    chk("R4", "write with dval_n high completes", 32'(w), 32'd2);
    m0_xfer(1, 12'h600, 0, 0, v, w);
    chk("R4", "unit 2 written", v, 32'h0000_6606);
    m0_xfer(0, 12'h100, 32'h0000_B001, 1, v, w);
    chk("R4", "burst in mode 0 wait cycles", 32'(w), 32'd0);
    pop_in(v);
    chk("R13", "input FIFO head", v, 32'h0000_B001);
    chk("R4", "burst in mode 0 gives one word", 32'(in_empty), 32'd1);
  endtask

  task automatic t_endian();
    logic [31:0] v; int w;
    big_end = 0;
    m0_xfer(0, 12'h400, 32'h1122_3344, 0, v, w);
    big_end = 1;
    m0_xfer(1, 12'h400, 0, 0, v, w);
    chk("R9", "little write, big read", v, 32'h4433_2211);
    big_end = 0;
    m0_xfer(1, 12'h400, 0, 0, v, w);
    chk("R9", "little write, little read", v, 32'h1122_3344);
    big_end = 1;
  endtask

  task automatic t_m1_single();
    mode_sel = 1;
    beat_wd[0] = 32'hD00D_0003;
    m1_xfer(0, 12'h700, 0, 1);
    chk("R5", "unit write wait cycles", 32'(first_waits), 32'd2);
    m1_xfer(1, 12'h700, 0, 1);
    chk("R5", "unit 3 readback", beat_rd[0], 32'hD00D_0003);
    chk("R5", "unit read wait cycles", 32'(first_waits), 32'd2);
  endtask

  task automatic t_m1_bursts();
    logic [31:0] v;
    int bad = 0;
    for (int i = 0; i < 4; i++) beat_wd[i] = 32'hF000_0010 + 32'(i);
    m1_xfer(0, 12'h100, 1, 4);
    chk("R6", "burst write first wait", 32'(first_waits), 32'd2);
    chk("R6", "burst write later waits", 32'(later_waits), 32'd0);
    for (int i = 0; i < 4; i++) begin
      pop_in(v);
      if (v !== 32'hF000_0010 + 32'(i)) bad++;
    end
    chk("R13", "input FIFO burst order errors", 32'(bad), 32'd0);
    for (int i = 0; i < 4; i++) push_out(32'hE000_0020 + 32'(i));
    m1_xfer(1, 12'h200, 1, 4);
    chk("R6", "burst read first wait", 32'(first_waits), 32'd2);
    chk("R6", "burst read later waits", 32'(later_waits), 32'd0);
    bad = 0;
    for (int i = 0; i < 4; i++) if (beat_rd[i] !== 32'hE000_0020 + 32'(i)) bad++;
    chk("R6", "burst read data errors", 32'(bad), 32'd0);
  endtask

  task automatic t_m1_burst_eu();
    beat_wd[0] = 32'h0000_0077;
    m1_xfer(0, 12'h600, 1, 1);
    chk("R7", "burst to unit wait cycles", 32'(first_waits), 32'd2);
    dval_n = 0; wdata = 32'h0000_0088;
    @(negedge clk);
    dval_n = 1;
    m1_xfer(1, 12'h600, 0, 1);
    chk("R7", "burst to unit is one beat", beat_rd[0], 32'h0000_0077);
  endtask

  task automatic t_stall_in();
    logic [31:0] v; int w;
    int lows = 0;
    int bad = 0;
    mode_sel = 0;
    for (int i = 0; i < 128; i++) m0_xfer(0, 12'h100, 32'h1000 + 32'(i), 0, v, w);
    @(negedge clk);
    chk("R11", "dreq[0] when input FIFO full", 32'(dreq[0]), 32'd0);
    ts_n = 0; cs_n = 0; rd_wr = 0; addr = 12'h100; wdata = 32'h0000_BEEF;
    @(negedge clk);
    ts_n = 1; cs_n = 1;
    repeat (6) begin if (!ack_n) lows++; @(negedge clk); end
    chk("R10", "ack while input FIFO full", 32'(lows), 32'd0);
    in_pop = 1; v = in_data;
    @(negedge clk);
    in_pop = 0;
    chk("R13", "first popped word", v, 32'h1000);
    w = 0;
    while (ack_n && w < 20) begin w++; @(negedge clk); end
    chk("R10", "ack once space exists", 32'(ack_n), 32'd0);
    @(negedge clk);
    for (int i = 1; i < 128; i++) begin
      pop_in(v);
      if (v !== 32'h1000 + 32'(i)) bad++;
    end
    pop_in(v);
    chk("R10", "stalled word kept", v, 32'h0000_BEEF);
    chk("R13", "drain order errors", 32'(bad), 32'd0);
  endtask

  task automatic t_stall_out();
    int highs = 0;
    mode_sel = 1;
    @(negedge clk);
    cs_n = 0; rd_wr = 1; addr = 12'h200;
    @(negedge clk);
    cs_n = 1;
    repeat (5) begin if (wait_o) highs++; @(negedge clk); end
    chk("R10", "wait cycles on empty output FIFO", 32'(highs), 32'd5);
    out_push = 1; out_wdata = 32'hCAFE_0001;
    @(negedge clk);
    out_push = 0;
    chk("R10", "wait released after push", 32'(wait_o), 32'd0);
    chk("R10", "read data after stall", rdata, 32'hCAFE_0001);
    dval_n = 0;
    @(negedge clk);
    dval_n = 1;
    mode_sel = 0;
  endtask

  task automatic t_dma();
    logic [31:0] v; int w;
    m0_xfer(0, 12'h001, 32'h2, 0, v, w);
    @(negedge clk);
    chk("R11", "dreq select 10, output FIFO empty", 32'(dreq), 32'b01);
    push_out(32'h0000_0D0D);
    @(negedge clk);
    chk("R11", "dreq select 10, output FIFO has data", 32'(dreq), 32'b11);
    m0_xfer(1, 12'h001, 0, 0, v, w);
    chk("R8", "DMA select readback", v, 32'h2);
    m0_xfer(1, 12'h200, 0, 0, v, w);
    chk("R13", "output FIFO word", v, 32'h0000_0D0D);
    m0_xfer(0, 12'h001, 32'h0, 0, v, w);
  endtask

  task automatic t_irq();
    @(negedge clk);
    eu_irq = 4'b0100;
    @(negedge clk);
    chk("R12", "irq_n with one unit interrupt", 32'(irq_n), 32'd0);
    eu_irq = 4'b0000;
    @(negedge clk);
    chk("R12", "irq_n cleared", 32'(irq_n), 32'd1);
  endtask

  initial begin
    t_reset();
    t_m0_basic();
    t_m0_no_ts();
    t_m0_ignored();
    t_endian();
    t_m1_single();
    t_m1_bursts();
    t_m1_burst_eu();
    t_stall_in();
    t_stall_out();
    t_dma();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule